// File: doc/BRIEF.md
# Integer Compare to Condition Field

This block compares one register operand with either a second register operand or a 16-bit immediate from the instruction. It writes the outcome as a 4-bit code into one of eight condition fields held in a 32-bit condition register. The instruction picks signed or logical (unsigned) interpretation, register or immediate source, the destination field, and a width bit. The width bit asks for a full 64-bit compare or a compare of only the low 32 bits.

Two static configuration inputs describe the core the block sits in. One says whether the implementation is 64-bit. The other says whether a 32-bit implementation treats a set width bit as an illegal instruction. On a 64-bit core the width bit is honoured. On a 32-bit core the compare is always 32 bits wide, and a set width bit either traps or produces a warning pulse. An issued operation updates the condition register and the two flags on the next rising clock edge.

Top module: `cmp_crfield`

## Requirements
- R1: During and right after reset, `cr_out` is zero and `illegal_out` and `warn_out` are low.
- R2: With `cfg_is64`=1 and `op_wide`=1, the compare uses all 64 bits of both operands.
- R3: In a 32-bit compare, only the low 32 bits of each operand matter. A signed compare sign-extends them and a logical compare zero-extends them.
- R4: With `cfg_is64`=0, the compare is 32 bits wide whatever `op_wide` holds.
- R5: With `cfg_is64`=0, `op_wide`=1 and `cfg_trap_l`=1, `illegal_out` is high for the cycle after issue and `cr_out` does not change.
- R6: With `cfg_is64`=0, `op_wide`=1 and `cfg_trap_l`=0, the 32-bit compare is written and `warn_out` is high for the cycle after issue. `illegal_out` and `warn_out` are never high together.
- R7: With `op_use_imm`=1, `op_imm` replaces `src_b`. It is sign-extended when `op_signed`=1 and zero-extended when `op_signed`=0.
- R8: The written field is {LT, GT, EQ, SO} from bit 3 down to bit 0. SO copies `so_in`, and exactly one of LT, GT and EQ is set.
- R9: Field n (n = `op_bf`) occupies `cr_out[31-4n -: 4]`, so field 0 is bits 31:28. All other fields keep their values.
- R10: A cycle with `op_valid`=0 leaves `cr_out` unchanged and drives both flags low on the next cycle.
- R11: An operation on a 64-bit implementation, or one with `op_wide`=0, never raises either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_is64 | input | 1 | 1 for a 64-bit implementation |
| cfg_trap_l | input | 1 | 32-bit core: a set width bit is illegal |
| op_valid | input | 1 | Issue a compare this cycle |
| op_signed | input | 1 | 1 signed, 0 logical |
| op_use_imm | input | 1 | 1 use immediate as second operand |
| op_wide | input | 1 | Width bit: 1 asks for 64-bit compare |
| op_bf | input | 3 | Destination condition field |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| op_imm | input | 16 | Immediate operand |
| so_in | input | 1 | Summary-overflow value copied into the field |
| cr_out | output | 32 | Condition register, eight 4-bit fields |
| illegal_out | output | 1 | Illegal-instruction pulse |
| warn_out | output | 1 | Ignored-width-bit warning pulse |

## Verification
The assertions assume that every input is at a known level at each rising edge once reset is released. They also treat the configuration pair as steady within any one operation, so a flag pulse can be tied to the operation issued one cycle earlier. The stimulus drives every input on the falling edge from the first cycle. It holds the configuration constant within each random phase and changes it only between operations. Operand values are drawn so that upper and lower halves often differ in sign and magnitude, which makes width and extension errors visible.

// File: rtl/cmpcr_pkg.sv
package cmpcr_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crnib_t;
endpackage

// File: rtl/cmpcr_operand.sv
module cmpcr_operand #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  raw_a,
  input  logic [XLEN-1:0]  raw_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             sgn,
  input  logic             wide,
  output logic [XLEN:0]    opa,
  output logic [XLEN:0]    opb
);
  localparam int HALF = XLEN / 2;
  localparam int UPW  = XLEN - HALF;
  localparam int IPAD = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] v, input logic s);
    return {{IPAD{s & v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] fit_width(input logic [XLEN-1:0] v, input logic w,
                                                input logic s);
    if (w) return v;
    return {{UPW{s & v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  function automatic logic [XLEN:0] lift(input logic [XLEN-1:0] v, input logic s);
    return {s & v[XLEN-1], v};
  endfunction

  logic [XLEN-1:0] b_sel;

  always_comb begin
    b_sel = use_imm ? widen_imm(imm, sgn) : raw_b;
    opa   = lift(fit_width(raw_a, wide, sgn), sgn);
    opb   = lift(fit_width(b_sel, wide, sgn), sgn);
  end
endmodule

// File: rtl/cmpcr_core.sv
module cmpcr_core #(
  parameter int W = 65
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         gt,
  output logic         eq
);
  always_comb begin
    lt = $signed(a) < $signed(b);
    eq = (a == b);
    gt = ~lt & ~eq;
  end
endmodule

// File: rtl/cmpcr_file.sv
module cmpcr_file #(
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  parameter int SELW   = $clog2(NFIELD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SELW-1:0]      sel,
  input  logic [FW-1:0]        data,
  output logic [NFIELD*FW-1:0] cr
);
  logic [FW-1:0] fld_q [NFIELD];

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)                             fld_q[i] <= '0;
      else if (we && sel == SELW'(i))         fld_q[i] <= data;
    end
    assign cr[(NFIELD-1-i)*FW +: FW] = fld_q[i];
  end

  // R9: without a write the whole register holds
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cr));

  // R8: the written field carries exactly one relation bit
  a_r8_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $countones(fld_q[$past(sel)][FW-1:1]) == 1);
endmodule

// File: rtl/cmp_crfield.sv
module cmp_crfield #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 16,
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  parameter int SELW   = $clog2(NFIELD),
  parameter int CRW    = NFIELD * FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_is64,
  input  logic             cfg_trap_l,
  input  logic             op_valid,
  input  logic             op_signed,
  input  logic             op_use_imm,
  input  logic             op_wide,
  input  logic [SELW-1:0]  op_bf,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] op_imm,
  input  logic             so_in,
  output logic [CRW-1:0]   cr_out,
  output logic             illegal_out,
  output logic             warn_out
);
  import cmpcr_pkg::*;

  // named internal events
  logic        width_bad;   // width bit set on a 32-bit core
  logic        trap_evt;    // operation squashed as illegal
  logic        warn_evt;    // width bit ignored with warning
  logic        wr_evt;      // a field is written
  logic        wide_eff;
  logic [XLEN:0] opa, opb;
  logic        rel_lt, rel_gt, rel_eq;
  crnib_t      nib;
  logic        illegal_q, warn_q;

  always_comb begin
    width_bad = op_wide & ~cfg_is64;
    trap_evt  = op_valid & width_bad & cfg_trap_l;
    warn_evt  = op_valid & width_bad & ~cfg_trap_l;
    wr_evt    = op_valid & ~trap_evt;
    wide_eff  = op_wide & cfg_is64;
  end

  cmpcr_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .raw_a(src_a), .raw_b(src_b), .imm(op_imm), .use_imm(op_use_imm),
    .sgn(op_signed), .wide(wide_eff), .opa(opa), .opb(opb)
  );

  cmpcr_core #(.W(XLEN+1)) u_core (
    .a(opa), .b(opb), .lt(rel_lt), .gt(rel_gt), .eq(rel_eq)
  );

  always_comb begin
    nib.lt = rel_lt;
    nib.gt = rel_gt;
    nib.eq = rel_eq;
    nib.so = so_in;
  end

  cmpcr_file #(.NFIELD(NFIELD), .FW(FW), .SELW(SELW)) u_file (
    .clk(clk), .rst_n(rst_n), .we(wr_evt), .sel(op_bf), .data(nib), .cr(cr_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
      warn_q    <= 1'b0;
    end else begin
      illegal_q <= trap_evt;
      warn_q    <= warn_evt;
    end
  end

  assign illegal_out = illegal_q;
  assign warn_out    = warn_q;

  // R5: a trapped operation leaves the condition register untouched
  a_r5_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_out |-> $stable(cr_out));

  // R6: the two flags never coincide
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_out && warn_out));

  // R10: an idle cycle produces no flag
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !illegal_out && !warn_out);

  // R11: 64-bit cores never flag
  a_r11_wide_core_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cfg_is64) |=> !illegal_out && !warn_out);

  // R11: a clear width bit never flags
  a_r11_narrow_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_wide) |=> !illegal_out && !warn_out);
endmodule

// File: tb/sim_cmp_crfield.sv
module sim_cmp_crfield;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_is64, cfg_trap_l;
  logic        op_valid, op_signed, op_use_imm, op_wide;
  logic [2:0]  op_bf;
  logic [63:0] src_a, src_b;
  logic [15:0] op_imm;
  logic        so_in;
  logic [31:0] cr_out;
  logic        illegal_out, warn_out;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [31:0] model_cr;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_crfield u0 (
    .clk(clk), .rst_n(rst_n), .cfg_is64(cfg_is64), .cfg_trap_l(cfg_trap_l),
    .op_valid(op_valid), .op_signed(op_signed), .op_use_imm(op_use_imm),
    .op_wide(op_wide), .op_bf(op_bf), .src_a(src_a), .src_b(src_b),
    .op_imm(op_imm), .so_in(so_in), .cr_out(cr_out),
    .illegal_out(illegal_out), .warn_out(warn_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected 4-bit field, computed with native integer types
  function automatic logic [3:0] ref_nib(input logic [63:0] a, input logic [63:0] b,
                                         input logic [15:0] im, input logic use_im,
                                         input logic sg, input logic wd, input logic so);
    logic [63:0] bv;
    logic lt, eq;
    if (use_im) bv = sg ? 64'(longint'(shortint'(im))) : {48'd0, im};
    else        bv = b;
    if (wd) begin
      eq = (a == bv);
      lt = sg ? (longint'(a) < longint'(bv)) : (a < bv);
    end else begin
      eq = (a[31:0] == bv[31:0]);
      lt = sg ? (int'(a[31:0]) < int'(bv[31:0])) : (a[31:0] < bv[31:0]);
    end
    return {lt, ~lt & ~eq, eq, so};
  endfunction

  task automatic issue(input string req, input logic is64, input logic trp,
                       input logic sg, input logic ui, input logic wd, input logic [2:0] bf,
                       input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
                       input logic so);
    logic bad, exp_ill, exp_wrn;
    logic [3:0] nb;
    cfg_is64 = is64; cfg_trap_l = trp;
    op_valid = 1'b1; op_signed = sg; op_use_imm = ui; op_wide = wd;
    op_bf = bf; src_a = a; src_b = b; op_imm = im; so_in = so;
    bad     = wd & ~is64;
    exp_ill = bad & trp;
    exp_wrn = bad & ~trp;
    nb = ref_nib(a, b, im, ui, sg, wd & is64, so);
    if (!exp_ill) model_cr[31 - 4*bf -: 4] = nb;
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " cr_out"}, cr_out, model_cr);
    check({req, " illegal_out"}, {31'd0, illegal_out}, {31'd0, exp_ill});
    check({req, " warn_out"}, {31'd0, warn_out}, {31'd0, exp_wrn});
  endtask

  task automatic idle_cycle();
    op_valid = 1'b0;
    src_a = 64'hFFFF_FFFF_FFFF_FFFF;
    op_bf = 3'd0;
    @(negedge clk);
    check("R10 idle cr_out", cr_out, model_cr);
    check("R10 idle flags", {30'd0, illegal_out, warn_out}, 32'd0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_is64 = 1'b1; cfg_trap_l = 1'b0;
    op_valid = 1'b0; op_signed = 1'b0; op_use_imm = 1'b0; op_wide = 1'b0;
    op_bf = '0; src_a = '0; src_b = '0; op_imm = '0; so_in = 1'b0;
    model_cr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset cr_out", cr_out, 32'd0);
    check("R1 reset flags", {30'd0, illegal_out, warn_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset cr_out", cr_out, 32'd0);

    // R2: upper halves decide, low halves would say otherwise
    issue("R2 wide signed", 1, 0, 1, 0, 1, 3'd0, 64'hFFFF_FFFF_0000_0005,
          64'h0000_0001_0000_0001, 16'h0, 0);
    issue("R2 wide logical", 1, 0, 0, 0, 1, 3'd7, 64'hFFFF_FFFF_0000_0005,
          64'h0000_0001_0000_0001, 16'h0, 1);
    // R3: narrow compare, low words equal, upper differ
    issue("R3 narrow eq", 1, 0, 1, 0, 0, 3'd1, 64'h1234_0000_0000_00AA,
          64'hFFFF_0000_0000_00AA, 16'h0, 0);
    // R3: 0x80000000 negative signed, large logical
    issue("R3 narrow signed sext", 1, 0, 1, 0, 0, 3'd2, 64'h0000_0000_8000_0000,
          64'h0000_0000_0000_0001, 16'h0, 0);
    issue("R3 narrow logical zext", 1, 0, 0, 0, 0, 3'd3, 64'h0000_0000_8000_0000,
          64'h0000_0000_0000_0001, 16'h0, 0);
    // R7: immediate 0xFFFF is -1 signed, 65535 logical
    issue("R7 imm signed", 1, 0, 1, 1, 1, 3'd4, 64'd0, 64'h5555, 16'hFFFF, 0);
    issue("R7 imm logical", 1, 0, 0, 1, 1, 3'd5, 64'd70000, 64'h5555, 16'hFFFF, 1);
    // R4, R6: 32-bit core, width bit ignored with warning
    issue("R4 R6 warn", 0, 0, 1, 0, 1, 3'd6, 64'h7FFF_FFFF_0000_0002,
          64'h0000_0000_0000_0003, 16'h0, 0);
    // R4: 32-bit core, width bit clear
    issue("R4 narrow core", 0, 1, 0, 0, 0, 3'd0, 64'hFFFF_FFFF_0000_0009,
          64'h0000_0000_0000_0009, 16'h0, 1);
    // R5: trap, no write even though bf points at a live field
    issue("R5 trap", 0, 1, 1, 0, 1, 3'd2, 64'h1, 64'h2, 16'h0, 1);
    idle_cycle();

    // random phases with fixed configuration per phase
    for (int ph = 0; ph < 4; ph++) begin
      logic is64, trp;
      is64 = ph[0];
      trp  = ph[1];
      for (int k = 0; k < 150; k++) begin
        logic [63:0] a, b;
        a = {$urandom(), $urandom()};
        b = ($urandom() % 4 == 0) ? a ^ {$urandom(), 32'd0} : {$urandom(), $urandom()};
        issue("R8 R9 random", is64, trp, 1'($urandom()), 1'($urandom()), 1'($urandom()),
              3'($urandom()), a, b, 16'($urandom()), 1'($urandom()));
        if (k % 25 == 0) idle_cycle();
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule